// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Register

This block gathers exception reports from floating-point arithmetic units into six sticky flags and raises an interrupt request when an enabled exception is reported. Each cycle the units present a vector of set attempts, one bit per exception kind. A set attempt latches its flag, and the flag stays set until software clears it. Software clears flags in one of two ways. It can write the flag word directly, or it can strobe a read, which clears every flag on the clock edge after the strobe. The flag word is always visible on `status_q`, so the value seen during the read strobe is the value being consumed.

A separate control word holds one interrupt enable per exception and a 2-bit rounding mode. Software loads the whole control word in one transfer over a valid/ready handshake.
- `ctl_wr_ready` is low while `fpu_busy` reports that the arithmetic units are still working.
- While ready is low, the writer must keep `ctl_wr_valid` and `ctl_wr_data` steady.
- A transfer completes on an edge where valid and ready are both high.

The interrupt request is a single-cycle pulse. It is raised for every set attempt on an enabled exception, whether or not the flag was already set. Turning an enable on while its flag is already set does not raise it.

Top module: `fp_exc_status`

## Requirements
- R1: After reset, all flags, all enables, the rounding mode and `irq` are 0, and `ctl_wr_ready` follows `!fpu_busy`.
- R2: A set attempt on bit i of `set_req` makes flag i read 1 on `status_q` after the next clock edge. The bit positions are: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid, 5 operand range.
- R3: A set flag stays set while neither a read strobe nor a status write occurs.
- R4: A cycle with `rd_clr` high leaves `status_q` unchanged during that cycle and clears all flags at the following edge.
- R5: A set attempt in the same cycle as a read strobe wins: the attempted bits end up 1.
- R6: A status write replaces the flags with `st_wr_data`, ORed with any set attempt in the same cycle. A status write takes precedence over a read strobe in the same cycle.
- R7: `irq` is high for exactly one cycle, following every cycle in which some bit has both its enable and its set attempt at 1, even if that flag is already set.
- R8: Enabling an exception whose flag is already 1 does not raise `irq`. A set attempt on a disabled bit raises no `irq`.
- R9: Control transfers are accepted only while `fpu_busy` is 0. Control word layout: bits [5:0] are the enables (same positions as R2), bits [7:6] are the rounding mode. While busy, enables and mode hold.
- R10: `irq` uses the enables held before the edge. A control write in the same cycle as a set attempt takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_req | input | 6 | Per-cycle set attempts from the arithmetic units |
| status_q | output | 6 | Current sticky flag word |
| rd_clr | input | 1 | Read strobe; clears all flags at the edge |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 6 | Value for a status write |
| ctl_wr_valid | input | 1 | Control transfer valid |
| ctl_wr_ready | output | 1 | Control transfer ready (low while busy) |
| ctl_wr_data | input | 8 | Control word: enables [5:0], rounding mode [7:6] |
| fpu_busy | input | 1 | Arithmetic units still active |
| exc_en | output | 6 | Current interrupt enables |
| round_mode | output | 2 | Current rounding mode |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Two groups of operations can collide in one cycle.

The first is a flag clear against a set attempt. The bench raises `rd_clr`, or a status write, in the same cycle as a `set_req` bit. It then checks that the attempted bit survives while the other flags clear or take the written value.

The second is a control write against a set attempt. The bench loads new enables in the same cycle as a set attempt and judges `irq` by the enables held before that edge. It also turns an enable on over an already-set flag and checks that no pulse follows.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;
  localparam int unsigned EXC_N = 6;
  localparam int unsigned RM_W  = 2;
  localparam int unsigned CTL_W = EXC_N + RM_W;

  localparam int unsigned EXC_INEXACT  = 0;
  localparam int unsigned EXC_UNDER    = 1;
  localparam int unsigned EXC_OVER     = 2;
  localparam int unsigned EXC_DIVZERO  = 3;
  localparam int unsigned EXC_INVALID  = 4;
  localparam int unsigned EXC_RANGE    = 5;

  typedef struct packed {
    logic [RM_W-1:0]  rmode;
    logic [EXC_N-1:0] en;
  } ctl_word_t;
endpackage

// File: rtl/exc_flag_bank.sv
module exc_flag_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_req,
  input  logic         rd_clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] flags
);
  logic [W-1:0] base;

  // one slice per flag: write value, else cleared by read, else held
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (wr_en)       base[i] = wr_data[i];
      else if (rd_clr) base[i] = 1'b0;
      else             base[i] = flags[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= base[i] | set_req[i];
    end
  end

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !wr_en) |=> ((flags & $past(flags)) == $past(flags)));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_en && set_req == '0) |=> (flags == '0));
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_req) |=> ((flags & $past(set_req)) == $past(set_req)));
endmodule

// File: rtl/exc_ctl_reg.sv
module exc_ctl_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         busy,
  output logic         wr_ready,
  output logic [W-1:0] ctl_q
);
  logic take;

  assign wr_ready = !busy;
  assign take     = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    ctl_q <= '0;
    else if (take) ctl_q <= wr_data;
  end

  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_q));
  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !busy) |=> (ctl_q == $past(wr_data)));
endmodule

// File: rtl/exc_irq_gen.sv
module exc_irq_gen #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en,
  input  logic [W-1:0] set_req,
  output logic         irq
);
  logic [W-1:0] hit;

  assign hit = en & set_req;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |hit;
  end

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en & set_req)) |=> irq);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req == '0) |=> !irq);
endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status
  import fp_exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXC_N-1:0] set_req,
  output logic [EXC_N-1:0] status_q,
  input  logic             rd_clr,
  input  logic             st_wr_en,
  input  logic [EXC_N-1:0] st_wr_data,
  input  logic             ctl_wr_valid,
  output logic             ctl_wr_ready,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             fpu_busy,
  output logic [EXC_N-1:0] exc_en,
  output logic [RM_W-1:0]  round_mode,
  output logic             irq
);
  ctl_word_t  ctl;
  logic [CTL_W-1:0] ctl_raw;

  exc_flag_bank #(.W(EXC_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .rd_clr(rd_clr),
    .wr_en(st_wr_en), .wr_data(st_wr_data), .flags(status_q)
  );

  exc_ctl_reg #(.W(CTL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_valid(ctl_wr_valid), .wr_data(ctl_wr_data),
    .busy(fpu_busy), .wr_ready(ctl_wr_ready), .ctl_q(ctl_raw)
  );

  assign ctl        = ctl_word_t'(ctl_raw);
  assign exc_en     = ctl.en;
  assign round_mode = ctl.rmode;

  exc_irq_gen #(.W(EXC_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(exc_en), .set_req(set_req), .irq(irq)
  );

  a_r1_ready_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_ready == !fpu_busy);
endmodule

// File: tb/fp_exc_status_tb.sv
module fp_exc_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] set_req = '0;
  logic [5:0] status_q;
  logic       rd_clr = 1'b0;
  logic       st_wr_en = 1'b0;
  logic [5:0] st_wr_data = '0;
  logic       ctl_wr_valid = 1'b0;
  logic       ctl_wr_ready;
  logic [7:0] ctl_wr_data = '0;
  logic       fpu_busy = 1'b0;
  logic [5:0] exc_en;
  logic [1:0] round_mode;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_exc_status u_dut (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .status_q(status_q),
    .rd_clr(rd_clr), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .ctl_wr_valid(ctl_wr_valid), .ctl_wr_ready(ctl_wr_ready),
    .ctl_wr_data(ctl_wr_data), .fpu_busy(fpu_busy), .exc_en(exc_en),
    .round_mode(round_mode), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    set_req = '0; rd_clr = 0; st_wr_en = 0; st_wr_data = '0;
    ctl_wr_valid = 0; ctl_wr_data = '0; fpu_busy = 0;
  endtask

  // drive before negedge, apply edge, sample 1 ns after posedge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic stim_at_neg();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", {2'b0, status_q}, 8'h00);
    chk("R1 enables", {2'b0, exc_en}, 8'h00);
    chk("R1 mode", {6'b0, round_mode}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 ready", {7'b0, ctl_wr_ready}, 8'h01);
  endtask

  task automatic t_set_sticky();
    stim_at_neg(); set_req = 6'b000100; step();
    chk("R2 set overflow", {2'b0, status_q}, 8'h04);
    stim_at_neg(); idle(); step(); step(); step();
    chk("R3 sticky", {2'b0, status_q}, 8'h04);
    chk("R8 disabled no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_read_clear();
    stim_at_neg(); rd_clr = 1; #1;
    chk("R4 visible during read", {2'b0, status_q}, 8'h04);
    step();
    chk("R4 cleared after read", {2'b0, status_q}, 8'h00);
    stim_at_neg(); idle();
  endtask

  task automatic t_read_vs_set();
    stim_at_neg(); set_req = 6'b000001; step();
    stim_at_neg(); set_req = 6'b010000; rd_clr = 1; step();
    chk("R5 set wins over read", {2'b0, status_q}, 8'h10);
    stim_at_neg(); idle(); rd_clr = 1; step();
    stim_at_neg(); idle(); step();
    chk("R4 cleared", {2'b0, status_q}, 8'h00);
  endtask

  task automatic t_sw_write();
    stim_at_neg(); st_wr_en = 1; st_wr_data = 6'b100010; set_req = 6'b000001; rd_clr = 1; step();
    chk("R6 write or set", {2'b0, status_q}, 8'h23);
    stim_at_neg(); idle(); st_wr_en = 1; st_wr_data = 6'b000000; step();
    chk("R6 write zero", {2'b0, status_q}, 8'h00);
    stim_at_neg(); idle();
  endtask

  task automatic t_ctl_busy();
    stim_at_neg(); fpu_busy = 1; ctl_wr_valid = 1; ctl_wr_data = {2'b10, 6'b111111}; #1;
    chk("R9 ready low when busy", {7'b0, ctl_wr_ready}, 8'h00);
    step(); step();
    chk("R9 held while busy", {2'b0, exc_en}, 8'h00);
    stim_at_neg(); fpu_busy = 0; step();
    chk("R9 accepted enables", {2'b0, exc_en}, 8'h3f);
    chk("R9 accepted mode", {6'b0, round_mode}, 8'h02);
    stim_at_neg(); idle();
  endtask

  task automatic t_irq();
    stim_at_neg(); set_req = 6'b001000; step();
    chk("R7 irq pulse", {7'b0, irq}, 8'h01);
    stim_at_neg(); idle(); step();
    chk("R7 irq one cycle", {7'b0, irq}, 8'h00);
    stim_at_neg(); set_req = 6'b001000; step();
    chk("R7 irq on already set", {7'b0, irq}, 8'h01);
    stim_at_neg(); idle(); step();
  endtask

  task automatic t_enable_on_set();
    stim_at_neg(); ctl_wr_valid = 1; ctl_wr_data = 8'h00; step();
    stim_at_neg(); idle(); step();
    chk("R8 flag still set", {2'b0, status_q}, 8'h08);
    stim_at_neg(); ctl_wr_valid = 1; ctl_wr_data = 8'h3f; step();
    stim_at_neg(); idle(); step();
    chk("R8 no irq on enable", {7'b0, irq}, 8'h00);
    step();
    chk("R8 still no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_en_timing();
    stim_at_neg(); ctl_wr_valid = 1; ctl_wr_data = 8'h00; set_req = 6'b000010; step();
    chk("R10 old enable used", {7'b0, irq}, 8'h01);
    stim_at_neg(); idle(); set_req = 6'b000010; step();
    chk("R10 new enable used", {7'b0, irq}, 8'h00);
    stim_at_neg(); idle(); ctl_wr_valid = 1; ctl_wr_data = 8'h01; step();
    stim_at_neg(); idle(); set_req = 6'b000010; step();
    chk("R8 masked bit no irq", {7'b0, irq}, 8'h00);
    stim_at_neg(); idle(); set_req = 6'b000001; step();
    chk("R7 enabled bit irq", {7'b0, irq}, 8'h01);
    stim_at_neg(); idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_set_sticky();
    t_read_clear();
    t_read_vs_set();
    t_sw_write();
    t_ctl_busy();
    t_irq();
    t_enable_on_set();
    t_en_timing();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule